// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Eight-Word Queue

This block takes 32-bit avionics data words from a host over a 16-bit write port and queues them. It sends each word on a two-wire, bipolar, return-to-zero digital drive: one wire for ones and one wire for zeros. The host writes the low half of a word and then the high half. The high-half write commits the whole word to an eight-entry queue. Flags tell the host when the queue is full and when it is empty.

When the enable input is high and a word is waiting, the transmitter pops the word and sends its 32 bits one per bit cell. Each cell drives the ones wire or the zeros wire for the first half of the cell and leaves both wires idle for the second half. The cell length is 10 or 80 master-clock cycles, chosen by a rate-select input. With a 1 MHz master clock this gives 100 kbit/s or 12.5 kbit/s. Words go out back to back with a fixed idle gap between them. Optionally, the last bit is replaced by an odd-parity bit. The analog line driver sits outside this block.

Top module: `a429_tx`

## Requirements
- R1: A write with `wr_hi`=0 only stores the low half (host bits 15:0). A word enters the queue only on a write with `wr_hi`=1. That word is {`wr_data`, last stored low half}.
- R2: The queue holds 8 words. `fifo_full` is 1 exactly when 8 words are held, and `fifo_empty` is 1 exactly when none are held. A high-half write while full is dropped, and the dropped word is never sent.
- R3: Words are sent in the order they were committed.
- R4: Host word bit 0 corresponds to serial bit 1. The wire order is host bits 7,6,...,0 (label, most significant first), then host bits 8,9,...,31.
- R5: A one drives `line_hi` and a zero drives `line_lo`, only during the first half of the bit cell. Both are 0 in the second half. They are never 1 together, and one never follows the other without an idle cycle between.
- R6: A bit cell lasts 10 clocks when `rate_sel`=0 and 80 clocks when `rate_sel`=1. The driven part lasts 5 or 40 clocks respectively. `rate_sel` is changed only while nothing is being sent.
- R7: When another word is queued and `tx_en` is high, the first cell of the next word begins exactly 4 bit cells after the last cell of the previous word ends.
- R8: With `par_en`=1, host bit 31 is replaced by the value that makes the sent 32 bits contain an odd number of ones. With `par_en`=0, bit 31 is sent as written.
- R9: No word starts while `tx_en` is 0, and the queued words stay queued.
- R10: After reset the queue is empty, `fifo_full` is 0, and both drive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (1 MHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per half-word |
| wr_hi | input | 1 | 0: write low half; 1: write high half and commit the word |
| wr_data | input | 16 | Half-word from the host |
| rate_sel | input | 1 | 0: cell of 10 clocks; 1: cell of 80 clocks |
| par_en | input | 1 | Replace bit 31 with odd parity |
| tx_en | input | 1 | Allow words to be started |
| fifo_full | output | 1 | Queue holds 8 words |
| fifo_empty | output | 1 | Queue holds no words |
| line_hi | output | 1 | Drive for a one bit |
| line_lo | output | 1 | Drive for a zero bit |

## Verification
The bench targets the split-write commit: a design that enqueued on the low half would clear `fifo_empty` too early. It targets the ninth write into a full queue: a design that accepted it would either send a ninth word or overwrite the oldest one. The bench decodes every serial word on the two wires and measures the drive width, the idle width and the inter-word gap in clock cycles. A wrong divider, a missing gap or a reversed label then shows up as a timing or data mismatch. The parity setting is checked with words of both parities: a design that forced or ignored the parity bit would send a different bit 31 on half of them.

// File: rtl/a429_tx.sv
module a429_tx #(
  parameter int DEPTH     = 8,
  parameter int DIV_FAST  = 10,
  parameter int DIV_SLOW  = 80,
  parameter int GAP_CELLS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [15:0] wr_data,
  input  logic        rate_sel,
  input  logic        par_en,
  input  logic        tx_en,
  output logic        fifo_full,
  output logic        fifo_empty,
  output logic        line_hi,
  output logic        line_lo
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DIV_SLOW);

  typedef enum logic [1:0] {IDLE, SEND, GAP} st_t;

  logic [15:0]   lo_q;
  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  st_t           st;
  logic [CW-1:0] tcnt;
  logic [4:0]    bcnt;
  logic [31:0]   sh;
  logic [31:0]   word, fixed, ld;

  wire push = wr_en && wr_hi && !fifo_full;
  wire idle = (st == IDLE);
  wire [CW-1:0] div_m1 = rate_sel ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
  wire [CW-1:0] half   = rate_sel ? CW'(DIV_SLOW / 2) : CW'(DIV_FAST / 2);
  wire cell_end = (tcnt >= div_m1);
  wire gap_done = (st == GAP) && cell_end && (bcnt == 5'(GAP_CELLS - 1));
  wire pop = tx_en && !fifo_empty && (idle || gap_done);

  assign fifo_full  = (cnt == (AW+1)'(DEPTH));
  assign fifo_empty = (cnt == '0);

  wire drive = (st == SEND) && (tcnt < half);
  assign line_hi = drive && sh[0];
  assign line_lo = drive && !sh[0];

  assign word  = mem[rp];
  assign fixed = par_en ? {~^word[30:0], word[30:0]} : word;

  always_comb begin
    ld = fixed;
    for (int i = 0; i < 8; i++) ld[i] = fixed[7-i];
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wr_hi) lo_q <= wr_data;
    if (push) mem[wp] <= {wr_data, lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      tcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
    end else if (pop) begin
      st   <= SEND;
      tcnt <= '0;
      bcnt <= '0;
      sh   <= ld;
    end else begin
      case (st)
        SEND: if (cell_end) begin
          tcnt <= '0;
          sh   <= sh >> 1;
          if (bcnt == 5'd31) begin
            st   <= GAP;
            bcnt <= '0;
          end else bcnt <= bcnt + 1'b1;
        end else tcnt <= tcnt + 1'b1;
        GAP: if (cell_end) begin
          tcnt <= '0;
          if (gap_done) begin
            st   <= IDLE;
            bcnt <= '0;
          end else bcnt <= bcnt + 1'b1;
        end else tcnt <= tcnt + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_hi,
  input logic tx_en,
  input logic fifo_full,
  input logic fifo_empty,
  input logic line_hi,
  input logic line_lo,
  input logic idle,
  input logic pop
);
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_hi && line_lo));
  assert_rz_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_hi |=> !line_lo);
  assert_rz_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_lo |=> !line_hi);
  assert_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));
  assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !pop |=> fifo_full);
  assert_low_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty && !(wr_en && wr_hi) |=> fifo_empty);
  assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle && !tx_en |=> idle);
endmodule

bind a429_tx a429_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .tx_en(tx_en),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .line_hi(line_hi),
  .line_lo(line_lo), .idle(idle), .pop(pop)
);

// File: tb/sim_a429_tx.sv
`timescale 1ns/1ps
module sim_a429_tx;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_hi = 0, rate_sel = 0, par_en = 0, tx_en = 0;
  logic [15:0] wr_data = '0;
  logic fifo_full, fifo_empty, line_hi, line_lo;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  a429_tx u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .rate_sel(rate_sel), .par_en(par_en), .tx_en(tx_en), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .line_hi(line_hi), .line_lo(line_lo));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_half(input bit hi, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_hi = hi; wr_data = d;
    @(negedge clk); wr_en = 0; wr_hi = 0;
  endtask

  function automatic logic [31:0] gen(input int k, input int cfg);
    case (k)
      0: return 32'h12345678 ^ cfg;
      1: return 32'h0;
      2: return 32'hFFFFFFFF;
      3: return 32'h1 << (cfg * 7 + 3);
      default: return (k * 32'h9E3779B9) ^ (cfg << 20);
    endcase
  endfunction

  task automatic recv(input int div, input bit more, output logic [31:0] got,
                      output bit t_ok, output bit g_ok, output bit x_ok);
    logic [31:0] bits;
    int n, m;
    t_ok = 1; g_ok = 1; x_ok = 1;
    while (!(line_hi || line_lo)) @(negedge clk);
    for (int b = 0; b < 32; b++) begin
      bits[b] = line_hi;
      n = 0;
      while (line_hi || line_lo) begin
        if (line_hi && line_lo) x_ok = 0;
        if (line_hi != bits[b]) x_ok = 0;
        n++; @(negedge clk);
      end
      if (n != div / 2) t_ok = 0;
      if (b < 31 || more) begin
        m = 0;
        while (!(line_hi || line_lo)) begin m++; @(negedge clk); end
        if (b < 31 && m != div - div / 2) t_ok = 0;
        if (b == 31 && m != div - div / 2 + 4 * div) g_ok = 0;
      end
    end
    got = bits;
    for (int i = 0; i < 8; i++) got[7-i] = bits[i];
  endtask

  task automatic quiet(input int cyc, output bit ok);
    ok = 1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (line_hi || line_lo) ok = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] exp [8];
    logic [31:0] got, w;
    bit t_ok, g_ok, x_ok, q_ok;
    int div;
    repeat (4) @(negedge clk);
    check(fifo_empty && !fifo_full && !line_hi && !line_lo, "R10 reset state",
          {28'h0, fifo_empty, fifo_full, line_hi, line_lo}, 32'h8);
    @(negedge clk); rst_n = 1;

    for (int cfg = 0; cfg < 4; cfg++) begin
      rate_sel = cfg[1]; par_en = cfg[0]; tx_en = 0;
      div = rate_sel ? 80 : 10;
      for (int k = 0; k < 8; k++) begin
        w = gen(k, cfg);
        exp[k] = par_en ? {~^w[30:0], w[30:0]} : w;
        write_half(0, w[15:0]);
        if (k == 0) begin
          repeat (3) @(negedge clk);
          check(fifo_empty, "R1 low half alone does not enqueue", {31'h0, fifo_empty}, 32'h1);
        end
        write_half(1, w[31:16]);
        if (k == 0) check(!fifo_empty, "R1 high half commits", {31'h0, fifo_empty}, 32'h0);
        if (k == 6) check(!fifo_full, "R2 not full at 7", {31'h0, fifo_full}, 32'h0);
      end
      check(fifo_full, "R2 full at 8", {31'h0, fifo_full}, 32'h1);
      write_half(0, 16'hBEEF);
      write_half(1, 16'hDEAD);
      quiet(3 * div, q_ok);
      check(q_ok && fifo_full, "R9 no start while disabled", {30'h0, q_ok, fifo_full}, 32'h3);
      @(negedge clk); tx_en = 1;
      for (int k = 0; k < 8; k++) begin
        recv(div, k < 7, got, t_ok, g_ok, x_ok);
        check(got == exp[k], "R3 R4 R8 word content/order", got, exp[k]);
        check(t_ok, "R6 cell timing", {31'h0, t_ok}, 32'h1);
        check(x_ok, "R5 drive encoding", {31'h0, x_ok}, 32'h1);
        if (k < 7) check(g_ok, "R7 inter-word gap", {31'h0, g_ok}, 32'h1);
      end
      quiet(6 * div, q_ok);
      check(q_ok && fifo_empty, "R2 write to full queue dropped", {30'h0, q_ok, fifo_empty}, 32'h3);
      tx_en = 0;
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule